// File: doc/BRIEF.md
# Four-Channel Buffered PWM Generator

This block produces four independent pulse-width-modulated outputs and is programmed over a simple 32-bit register bus with single-cycle write and read strobes. Each channel counts prescaled clock ticks from zero up to its period minus one and then wraps. Its output level depends on whether the count is below the duty value, and a per-channel polarity bit flips that level. Every channel has its own power-of-two prescaler.

Software starts and stops channels through write-one-to-set and write-one-to-clear global registers, and reads a status word with one bit per running channel. While a channel is stopped, its duty and period are written directly. While it runs, new values go through update registers. They are held in a shadow buffer and copied into the active registers only when the period wraps, so the output never shows a partial cycle. Each wrap also sets a per-channel flag in an event register that clears when read. Software reads that register to confirm that an update was applied before it stops the channel.

Top module: `pwm4_ctrl`

## Requirements
- R1: After synchronous reset all channels are stopped, every output is low, and the status, event and channel registers read zero.
- R2: A write to offset 0x04 starts each channel whose data bit is 1. A write to 0x08 stops each channel whose data bit is 1. Zero bits change nothing. Offset 0x0C reads the running channels in bits 3:0.
- R3: Channel n's registers sit at 0x200 + n*0x20: mode at +0x0, duty at +0x4, update at +0x8, period at +0xC, period update at +0x10. Read data appears on the cycle after the read strobe. Unmapped offsets and the update registers read zero.
- R4: In the mode register, bits 3:0 hold the prescaler exponent, bit 9 the polarity and bit 10 the update target. Other bits read zero. Duty and period keep only their low 16 bits, and the upper bits read zero.
- R5: A running channel's counter goes 0..period-1 and then wraps (period 0 or 1 wraps on every tick). With polarity 0 the output is low while the counter is below duty and high otherwise. The output register follows the counter by one clock.
- R6: The counter advances once every 2^exponent clocks, counted from the clock at which the channel was started.
- R7: Polarity 1 inverts the output. A stopped channel drives its polarity bit as its idle level.
- R8: While a channel is stopped, writes to duty, period or either update register take effect at once. While it runs, direct writes to duty (+0x4) and period (+0xC) are ignored.
- R9: While a channel runs, a write to +0x8 goes to the pending duty when mode bit 10 is 0, and to the pending period when it is 1. A write to +0x10 always goes to the pending period. Pending values become active at the next wrap.
- R10: Offset 0x1C gets bit n set when channel n wraps. A read returns the pending bits and clears them. A wrap in the same cycle as the read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| pwm_out | output | NCH | Channel outputs |

## Verification
A wrong counter, prescaler phase or active duty shows up on pwm_out within one period of the affected channel, because the output is compared against the reference model on every clock. A shadow value that is loaded early or late shows up as an edge that moves by at least one tick around the wrap. It also shows in the duty or period readback taken right after that wrap. Errors in event-flag handling, such as a lost set or a missed clear, appear on the next read of 0x1C. The bench reads that register back-to-back to expose both.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int BUS_W  = 32;
  localparam int PRES_W = 4;
  localparam int POL_BIT = 9;
  localparam int SEL_BIT = 10;

  localparam logic [2:0] CW_MODE = 3'd0;
  localparam logic [2:0] CW_DUTY = 3'd1;
  localparam logic [2:0] CW_DUPD = 3'd2;
  localparam logic [2:0] CW_PRD  = 3'd3;
  localparam logic [2:0] CW_PUPD = 3'd4;

  localparam logic [6:0] GW_ENA  = 7'd1;
  localparam logic [6:0] GW_DIS  = 7'd2;
  localparam logic [6:0] GW_STAT = 7'd3;
  localparam logic [6:0] GW_EVT  = 7'd7;

  typedef struct packed {
    logic              sel;
    logic              pol;
    logic [PRES_W-1:0] pres;
  } mode_t;
endpackage

// File: rtl/pwm4_chan.sv
module pwm4_chan
  import pwm4_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             wr_mode_i,
  input  logic             wr_duty_i,
  input  logic             wr_prd_i,
  input  logic             wr_dupd_i,
  input  logic             wr_pupd_i,
  input  logic [BUS_W-1:0] wdata_i,
  output mode_t            mode_o,
  output logic [DW-1:0]    duty_o,
  output logic [DW-1:0]    period_o,
  output logic             wrap_o,
  output logic             pwm_o
);
  localparam int PCNT_W = 1 << PRES_W;

  mode_t             mode_q;
  logic [DW-1:0]     duty_q, prd_q, pduty_q, pprd_q, cnt_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic              out_q;

  logic [PCNT_W-1:0] mask;
  logic              tick, wrap;
  logic [DW-1:0]     data;
  logic              to_duty, to_prd;
  logic              unused_bits;

  assign data        = wdata_i[DW-1:0];
  assign unused_bits = ^{wdata_i[BUS_W-1:DW]};
  assign mask        = (PCNT_W'(1) << mode_q.pres) - PCNT_W'(1);
  assign tick        = (pcnt_q & mask) == mask;
  assign wrap        = en_i && tick && (({1'b0, cnt_q} + (DW+1)'(1)) >= {1'b0, prd_q});
  assign to_duty     = wr_dupd_i && !mode_q.sel;
  assign to_prd      = wr_pupd_i || (wr_dupd_i && mode_q.sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      duty_q  <= '0;
      prd_q   <= '0;
      pduty_q <= '0;
      pprd_q  <= '0;
      cnt_q   <= '0;
      pcnt_q  <= '0;
      out_q   <= 1'b0;
    end else begin
      out_q <= en_i ? (mode_q.pol ^ (cnt_q >= duty_q)) : mode_q.pol;
      if (wr_mode_i) begin
        mode_q.pres <= wdata_i[PRES_W-1:0];
        mode_q.pol  <= wdata_i[POL_BIT];
        mode_q.sel  <= wdata_i[SEL_BIT];
      end
      if (!en_i) begin
        cnt_q  <= '0;
        pcnt_q <= '0;
        if (wr_duty_i || to_duty) begin
          duty_q  <= data;
          pduty_q <= data;
        end
        if (wr_prd_i || to_prd) begin
          prd_q  <= data;
          pprd_q <= data;
        end
      end else begin
        pcnt_q <= pcnt_q + PCNT_W'(1);
        if (to_duty) pduty_q <= data;
        if (to_prd)  pprd_q  <= data;
        if (tick) begin
          if (wrap) begin
            cnt_q  <= '0;
            duty_q <= pduty_q;
            prd_q  <= pprd_q;
          end else begin
            cnt_q <= cnt_q + DW'(1);
          end
        end
      end
    end
  end

  assign mode_o   = mode_q;
  assign duty_o   = duty_q;
  assign period_o = prd_q;
  assign wrap_o   = wrap;
  assign pwm_o    = out_q;

  // Counter always stays inside the active period window (R5)
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (prd_q != '0) |-> (cnt_q < prd_q));

  // Active duty of a running channel changes only at a wrap (R9)
  assert_duty_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (en_i && !wrap) |=> $stable(duty_q));

  // A stopped channel drives its idle level (R7)
  assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (pwm_o == $past(mode_q.pol)));

  // Prescaled stepping: counter moves only on a tick (R6)
  assert_step_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (en_i && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm4_evt.sv
module pwm4_evt #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_i,
  input  logic           clr_i,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (clr_i ? '0 : pend_q) | set_i;
  end

  assign pend_o = pend_q;

  // Read clears everything except wraps landing in the same cycle (R10)
  assert_clear_on_read_R10: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pend_o == $past(set_i)));

  // Without a read, pending flags are sticky (R10)
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DW     = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int HI_W = ADDR_W - 9;

  logic           is_glob, is_chan;
  logic [3:0]     ch_idx;
  logic [6:0]     gword;
  logic [2:0]     cword;
  logic           unused_addr;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] wraps, pend;
  logic           evt_rd;
  logic [31:0]    rd_mux;

  mode_t         ch_mode [NCH];
  logic [DW-1:0] ch_duty [NCH];
  logic [DW-1:0] ch_prd  [NCH];

  assign is_glob     = bus_addr[ADDR_W-1:9] == '0;
  assign is_chan     = (bus_addr[ADDR_W-1:9] == HI_W'(1)) && (bus_addr[8:5] < 4'(NCH));
  assign ch_idx      = bus_addr[8:5];
  assign gword       = bus_addr[8:2];
  assign cword       = bus_addr[4:2];
  assign unused_addr = ^bus_addr[1:0];
  assign evt_rd      = bus_rd && is_glob && (gword == GW_EVT);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (bus_wr && is_glob) begin
      if (gword == GW_ENA) en_q <= en_q | bus_wdata[NCH-1:0];
      if (gword == GW_DIS) en_q <= en_q & ~bus_wdata[NCH-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = bus_wr && is_chan && (ch_idx == 4'(c));
    pwm4_chan #(.DW(DW)) chan_i (
      .clk       (clk),
      .rst       (rst),
      .en_i      (en_q[c]),
      .wr_mode_i (sel_c && (cword == CW_MODE)),
      .wr_duty_i (sel_c && (cword == CW_DUTY)),
      .wr_prd_i  (sel_c && (cword == CW_PRD)),
      .wr_dupd_i (sel_c && (cword == CW_DUPD)),
      .wr_pupd_i (sel_c && (cword == CW_PUPD)),
      .wdata_i   (bus_wdata),
      .mode_o    (ch_mode[c]),
      .duty_o    (ch_duty[c]),
      .period_o  (ch_prd[c]),
      .wrap_o    (wraps[c]),
      .pwm_o     (pwm_out[c])
    );
  end

  pwm4_evt #(.NCH(NCH)) evt_i (
    .clk    (clk),
    .rst    (rst),
    .set_i  (wraps),
    .clr_i  (evt_rd),
    .pend_o (pend)
  );

  always_comb begin
    rd_mux = '0;
    if (is_glob) begin
      if (gword == GW_STAT) rd_mux[NCH-1:0] = en_q;
      if (gword == GW_EVT)  rd_mux[NCH-1:0] = pend;
    end else if (is_chan) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_idx == 4'(c)) begin
          case (cword)
            CW_MODE: begin
              rd_mux[PRES_W-1:0] = ch_mode[c].pres;
              rd_mux[POL_BIT]    = ch_mode[c].pol;
              rd_mux[SEL_BIT]    = ch_mode[c].sel;
            end
            CW_DUTY: rd_mux[DW-1:0] = ch_duty[c];
            CW_PRD:  rd_mux[DW-1:0] = ch_prd[c];
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // Write-one start never drops a requested channel (R2)
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && is_glob && gword == GW_ENA) |=>
      ((en_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  // Write-one stop clears every requested channel (R2)
  assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && is_glob && gword == GW_DIS) |=>
      ((en_q & $past(bus_wdata[NCH-1:0])) == '0));

  // Unselected reads leave read data untouched (R3)
  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/pwm4_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm4_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        b_wr, b_rd;
  logic [11:0] b_addr;
  logic [31:0] b_wdata;
  logic [31:0] rdata;
  logic [3:0]  pwm;

  always #2 clk = ~clk;

  pwm4_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .pwm_out(pwm)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Behavioural reference model state
  int m_en[4], m_pres[4], m_pol[4], m_sel[4];
  int m_duty[4], m_prd[4], m_pd[4], m_pp[4], m_cnt[4], m_pc[4], m_out[4];
  int m_evt;
  int exp_rd;
  bit rd_chk;
  string rd_tag, cur_tag;

  function automatic int model_read(int a);
    int c, off;
    if (a == 'h0C) return (m_en[0] | m_en[1] << 1 | m_en[2] << 2 | m_en[3] << 3);
    if (a == 'h1C) return m_evt;
    if (a >= 'h200 && a < 'h280) begin
      c = (a - 'h200) / 32;
      off = (a - 'h200) % 32;
      if (off == 0) return m_pres[c] | (m_pol[c] << 9) | (m_sel[c] << 10);
      if (off == 4) return m_duty[c];
      if (off == 'hC) return m_prd[c];
    end
    return 0;
  endfunction

  always @(posedge clk) begin : model
    int a, d, off, wraps, mask;
    bit hit, tick, wrp, tod, top;
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        m_en[c] = 0; m_pres[c] = 0; m_pol[c] = 0; m_sel[c] = 0; m_duty[c] = 0;
        m_prd[c] = 0; m_pd[c] = 0; m_pp[c] = 0; m_cnt[c] = 0; m_pc[c] = 0; m_out[c] = 0;
      end
      m_evt = 0; rd_chk = 0;
    end else begin
      a = int'(b_addr); d = int'(b_wdata & 32'hFFFF);
      wraps = 0;
      rd_chk = b_rd;
      if (b_rd) begin exp_rd = model_read(a); rd_tag = cur_tag; end
      for (int c = 0; c < 4; c++)
        m_out[c] = m_en[c] ? (m_pol[c] ^ int'(m_cnt[c] >= m_duty[c])) : m_pol[c];
      for (int c = 0; c < 4; c++) begin
        hit = b_wr && (a >= 'h200 + c * 32) && (a < 'h200 + (c + 1) * 32);
        off = a - ('h200 + c * 32);
        tod = hit && off == 8 && m_sel[c] == 0;
        top = hit && (off == 'h10 || (off == 8 && m_sel[c] == 1));
        if (m_en[c] == 0) begin
          m_cnt[c] = 0; m_pc[c] = 0;
          if ((hit && off == 4) || tod) begin m_duty[c] = d; m_pd[c] = d; end
          if ((hit && off == 'hC) || top) begin m_prd[c] = d; m_pp[c] = d; end
        end else begin
          mask = (1 << m_pres[c]) - 1;
          tick = (m_pc[c] & mask) == mask;
          wrp  = tick && (m_cnt[c] + 1 >= m_prd[c]);
          m_pc[c] = (m_pc[c] + 1) & 'hFFFF;
          if (wrp) begin
            m_cnt[c] = 0; m_duty[c] = m_pd[c]; m_prd[c] = m_pp[c]; wraps |= 1 << c;
          end else if (tick) m_cnt[c]++;
          if (tod) m_pd[c] = d;
          if (top) m_pp[c] = d;
        end
        if (hit && off == 0) begin
          m_pres[c] = int'(b_wdata[3:0]); m_pol[c] = int'(b_wdata[9]); m_sel[c] = int'(b_wdata[10]);
        end
      end
      m_evt = ((b_rd && a == 'h1C) ? 0 : m_evt) | wraps;
      if (b_wr && a == 'h04) for (int c = 0; c < 4; c++) if (b_wdata[c]) m_en[c] = 1;
      if (b_wr && a == 'h08) for (int c = 0; c < 4; c++) if (b_wdata[c]) m_en[c] = 0;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin : cmp
    logic [3:0] ev;
    if (!rst && !done) begin
      for (int c = 0; c < 4; c++) ev[c] = m_out[c][0];
      n_cmp++;
      if (pwm !== ev) begin
        n_bad++;
        $display("FAIL R5/R6/R7 pwm_out at %0t: got %b exp %b", $time, pwm, ev);
      end
      if (rd_chk) begin
        n_cmp++;
        if (rdata !== 32'(exp_rd)) begin
          n_bad++;
          $display("FAIL %s read at %0t: got %h exp %h", rd_tag, $time, rdata, 32'(exp_rd));
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    b_wr = 1; b_addr = 12'(a); b_wdata = d;
    @(negedge clk);
    b_wr = 0;
  endtask

  task automatic rd(input int a, input string tag);
    b_rd = 1; b_addr = 12'(a); cur_tag = tag;
    @(negedge clk);
    b_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ca(input int c, input int off);
    return 'h200 + c * 32 + off;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin : stim
    rst = 1; b_wr = 0; b_rd = 0; b_addr = '0; b_wdata = '0; cur_tag = "R1";
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd('h0C, "R1"); rd('h1C, "R1"); rd(ca(0, 0), "R1"); rd(ca(2, 4), "R1");
    // R4 mode fields and 16-bit truncation
    wr(ca(0, 0), 32'hFFFF_F9F0);
    rd(ca(0, 0), "R4");
    wr(ca(0, 0), 32'h0000_0000);
    wr(ca(0, 4), 32'hABCD_0003);
    wr(ca(0, 'hC), 32'h1234_0008);
    rd(ca(0, 4), "R4"); rd(ca(0, 'hC), "R4");
    // R3 unmapped and write-only offsets
    rd(ca(0, 8), "R3"); rd(ca(1, 'h14), "R3"); rd('h100, "R3"); rd('h300, "R3");
    // R2 start ch0, R5 basic waveform
    wr('h04, 32'h1);
    rd('h0C, "R2");
    idle(40);
    // R6 R7 ch1 prescaled and inverted
    wr(ca(1, 0), 32'h0000_0202);
    idle(3);
    wr(ca(1, 4), 32'h2); wr(ca(1, 'hC), 32'h5);
    wr('h04, 32'h2);
    wr('h04, 32'h0);
    rd('h0C, "R2");
    idle(80);
    // R8 direct writes ignored while running
    wr(ca(0, 4), 32'h6); wr(ca(0, 'hC), 32'h3);
    rd(ca(0, 4), "R8"); rd(ca(0, 'hC), "R8");
    // R9 buffered duty update
    wr(ca(0, 8), 32'h6);
    rd(ca(0, 4), "R9");
    idle(10);
    rd(ca(0, 4), "R9");
    // R9 update target selected by bit 10, then period update register
    wr(ca(0, 0), 32'h0000_0400);
    wr(ca(0, 8), 32'hC);
    idle(12);
    rd(ca(0, 'hC), "R9");
    wr(ca(0, 'h10), 32'hA);
    idle(16);
    rd(ca(0, 'hC), "R9"); rd(ca(0, 4), "R9");
    // R10 clear on read, back-to-back
    rd('h1C, "R10"); rd('h1C, "R10");
    idle(7);
    rd('h1C, "R10");
    // R8 update writes and direct writes when stopped, R7 idle level
    wr('h08, 32'h2);
    rd('h0C, "R2");
    idle(4);
    wr(ca(1, 8), 32'h4);
    rd(ca(1, 4), "R8");
    // R5 boundaries: duty 0, duty >= period, period 0 and 1
    wr(ca(2, 4), 32'h0); wr(ca(2, 'hC), 32'h4);
    wr(ca(3, 4), 32'h9); wr(ca(3, 'hC), 32'h1);
    wr('h04, 32'hC);
    idle(30);
    wr('h08, 32'h8);
    wr(ca(3, 'hC), 32'h0); wr(ca(3, 4), 32'h0);
    wr('h04, 32'h8);
    idle(20);
    rd('h1C, "R10");
    // R6 large exponent
    wr('h08, 32'hF);
    wr(ca(2, 0), 32'h0000_000A); wr(ca(2, 4), 32'h1); wr(ca(2, 'hC), 32'h2);
    wr('h04, 32'h4);
    idle(4200);
    rd('h1C, "R10");
    rd('h0C, "R2");
    finish_run();
  end
endmodule